// File: doc/BRIEF.md
# Serial-flash boot header search sequencer

This block drives a lower-level SPI shifter during boot to find a valid image header in flash. Starting at a base address, it issues up to three read commands per candidate address, from fastest to most basic: an octal fast read with a 4-byte address, a single-lane read with a 4-byte address, and a basic single-lane read with a 3-byte address. After each command the shifter streams back the header words. If the identification word at a fixed position matches a parameterised constant, the search ends and the block reports the address it found.

If all three commands fail at an address, the sequencer moves forward by a fixed 32 KB stride and starts again with the octal command. When the configured number of addresses has been tried, or when the next address would leave the lower device of a dual-stacked pair, the block enters lockdown. Lockdown raises an error, forces a 32-bit tristate control word to all ones so the I/Os float, and blocks any further command requests until reset. Only single transfer rate commands are issued.

Top module: `hsrch_seq`

## Requirements
- R1: Out of reset, req_valid, done, found, lockdown and error_out are low and tristate_ctl is 0x00000000.
- R2: The first command at each address has opcode 0x7C, the full 32-bit header address, req_addr_bytes = 4, req_lanes = 8 and req_dummy = 8.
- R3: The second command at an address has opcode 0x13, the full 32-bit address, req_addr_bytes = 4, req_lanes = 1 and req_dummy = 0.
- R4: The third command at an address has opcode 0x03, req_addr_bytes = 3, req_lanes = 1, req_dummy = 0 and req_addr bits 31:24 forced to zero while bits 23:0 carry the header address.
- R5: At one address the commands are tried in the order 0x7C, 0x13, 0x03. A later command is issued only after the previous one has returned HDR_WORDS words without a valid header.
- R6: The first address searched is BASE_ADDR. After all three commands fail, the next address is the previous one plus 0x8000, and the search restarts with 0x7C.
- R7: A header is valid when returned word number ID_IDX (counting from 0) equals ID_WORD. The block then raises found and done, puts the header address on found_addr, and issues no further requests.
- R8: When all three commands fail at address number SEARCH_LIMIT-1, lockdown, error_out and done go high, found stays low, and tristate_ctl becomes 0xFFFFFFFF.
- R9: Lockdown is sticky until reset. While it holds, start and returned data are ignored and req_valid stays low.
- R10: With DUAL_STACK set, no address at or above 2**LOWER_SPAN_LOG2 is requested. The search enters lockdown instead, even before SEARCH_LIMIT is reached.
- R11: A pending request keeps req_valid high and all request fields stable until req_ready is seen.
- R12: req_len equals HDR_WORDS*4 bytes on every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the search when idle |
| req_valid | output | 1 | Command request pending |
| req_ready | input | 1 | Shifter accepts the request |
| req_opcode | output | 8 | Read opcode |
| req_addr | output | 32 | Flash address sent with the command |
| req_addr_bytes | output | 3 | Address length in bytes |
| req_lanes | output | 4 | Data lanes used for the read (1 or 8) |
| req_dummy | output | 4 | Dummy cycles after the address |
| req_len | output | LEN_W | Bytes to read |
| rx_valid | input | 1 | Returned header word valid |
| rx_data | input | 32 | Returned header word |
| done | output | 1 | Search finished (found or lockdown) |
| found | output | 1 | Valid header located |
| found_addr | output | 32 | Header address that matched |
| lockdown | output | 1 | Search exhausted, locked |
| error_out | output | 1 | Error indication during lockdown |
| tristate_ctl | output | 32 | I/O tristate control word |

## Verification
The main bench instance uses SEARCH_LIMIT = 4, HDR_WORDS = 4, ID_IDX = 2 and a base address of 0x01000000. A non-zero top byte makes the 3-byte truncation of the basic read visible. The small limit lets the bench sweep every (address, command) position of the matching header, plus the case with no match, so every step of the fallback ladder and the final lockdown is reached. A second instance with DUAL_STACK = 1 and a 64 KB lower span starts at address 0. There the span ends the search after two addresses, well before the limit of four.

// File: rtl/hsrch_pkg.sv
package hsrch_pkg;

    localparam int ADDR_W = 32;

    localparam logic [7:0] OP_OCTAL = 8'h7C;
    localparam logic [7:0] OP_WIDE  = 8'h13;
    localparam logic [7:0] OP_BASIC = 8'h03;

    typedef enum logic [1:0] {
        ATT_OCTAL = 2'd0,
        ATT_WIDE  = 2'd1,
        ATT_BASIC = 2'd2
    } attempt_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_RECV  = 3'd2,
        ST_FOUND = 3'd3,
        ST_LOCK  = 3'd4
    } state_e;

    typedef struct packed {
        logic [7:0]        opcode;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        addr_bytes;
        logic [3:0]        lanes;
        logic [3:0]        dummy;
    } cmd_t;

    typedef struct packed {
        state_e            state;
        attempt_e          attempt;
        logic              found;
        logic              lock;
        logic [ADDR_W-1:0] found_addr;
    } seq_t;

endpackage

// File: rtl/hsrch_cmd_table.sv
module hsrch_cmd_table
    import hsrch_pkg::*;
(
    input  attempt_e          attempt,
    input  logic [ADDR_W-1:0] hdr_addr,
    output cmd_t              cmd
);

    always_comb begin
        cmd = '0;
        case (attempt)
            ATT_OCTAL: begin
                cmd.opcode     = OP_OCTAL;
                cmd.addr       = hdr_addr;
                cmd.addr_bytes = 3'd4;
                cmd.lanes      = 4'd8;
                cmd.dummy      = 4'd8;
            end
            ATT_WIDE: begin
                cmd.opcode     = OP_WIDE;
                cmd.addr       = hdr_addr;
                cmd.addr_bytes = 3'd4;
                cmd.lanes      = 4'd1;
                cmd.dummy      = 4'd0;
            end
            default: begin
                cmd.opcode     = OP_BASIC;
                cmd.addr       = {8'h00, hdr_addr[23:0]};
                cmd.addr_bytes = 3'd3;
                cmd.lanes      = 4'd1;
                cmd.dummy      = 4'd0;
            end
        endcase
    end

endmodule

// File: rtl/hsrch_hdr_check.sv
module hsrch_hdr_check #(
    parameter int          HDR_WORDS = 4,
    parameter int          ID_IDX    = 2,
    parameter logic [31:0] ID_WORD   = 32'hA5C3_0F96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        rx_valid,
    input  logic [31:0] rx_data,
    output logic        complete,
    output logic        match
);

    localparam int CNT_W = $clog2(HDR_WORDS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             match;
    } chk_t;

    chk_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (en && rx_valid && (q.cnt < CNT_W'(HDR_WORDS))) begin
            if ((q.cnt == CNT_W'(ID_IDX)) && (rx_data == ID_WORD)) begin
                d.match = 1'b1;
            end
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign complete = (q.cnt == CNT_W'(HDR_WORDS));
    assign match    = q.match;

endmodule

// File: rtl/hsrch_addr_walk.sv
module hsrch_addr_walk #(
    parameter logic [31:0] BASE_ADDR       = 32'h0000_0000,
    parameter logic [31:0] STRIDE          = 32'h0000_8000,
    parameter int          SEARCH_LIMIT    = 4,
    parameter bit          DUAL_STACK      = 1'b0,
    parameter int          LOWER_SPAN_LOG2 = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        step,
    output logic [31:0] addr,
    output logic        last
);

    localparam int IDX_W = $clog2(SEARCH_LIMIT + 1);

    typedef struct packed {
        logic [31:0]      addr;
        logic [IDX_W-1:0] idx;
    } walk_t;

    walk_t d, q;
    logic [32:0] next_addr;
    logic        beyond;

    assign next_addr = {1'b0, q.addr} + {1'b0, STRIDE};

    generate
        if (DUAL_STACK) begin : g_dual
            localparam logic [32:0] SPAN_END = 33'd1 << LOWER_SPAN_LOG2;
            assign beyond = (next_addr >= SPAN_END);
        end else begin : g_single
            assign beyond = next_addr[32];
        end
    endgenerate

    always_comb begin
        d = q;
        if (load) begin
            d.addr = BASE_ADDR;
            d.idx  = '0;
        end else if (step) begin
            d.addr = next_addr[31:0];
            d.idx  = q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr = q.addr;
    assign last = (q.idx >= IDX_W'(SEARCH_LIMIT - 1)) || beyond;

endmodule

// File: rtl/hsrch_seq.sv
module hsrch_seq
    import hsrch_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR       = 32'h0000_0000,
    parameter int          SEARCH_LIMIT    = 8,
    parameter int          HDR_WORDS       = 4,
    parameter int          ID_IDX          = 2,
    parameter logic [31:0] ID_WORD         = 32'hA5C3_0F96,
    parameter bit          DUAL_STACK      = 1'b0,
    parameter int          LOWER_SPAN_LOG2 = 28,
    localparam int         LEN_W           = $clog2(HDR_WORDS * 4 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [7:0]       req_opcode,
    output logic [31:0]      req_addr,
    output logic [2:0]       req_addr_bytes,
    output logic [3:0]       req_lanes,
    output logic [3:0]       req_dummy,
    output logic [LEN_W-1:0] req_len,
    input  logic             rx_valid,
    input  logic [31:0]      rx_data,
    output logic             done,
    output logic             found,
    output logic [31:0]      found_addr,
    output logic             lockdown,
    output logic             error_out,
    output logic [31:0]      tristate_ctl
);

    localparam logic [31:0] STRIDE = 32'h0000_8000;

    seq_t d, q;

    logic        walk_load, walk_step, walk_last;
    logic [31:0] walk_addr;
    logic        chk_clr, chk_complete, chk_match;
    cmd_t        cmd;

    hsrch_addr_walk #(
        .BASE_ADDR      (BASE_ADDR),
        .STRIDE         (STRIDE),
        .SEARCH_LIMIT   (SEARCH_LIMIT),
        .DUAL_STACK     (DUAL_STACK),
        .LOWER_SPAN_LOG2(LOWER_SPAN_LOG2)
    ) u_walk (
        .clk  (clk),
        .rst_n(rst_n),
        .load (walk_load),
        .step (walk_step),
        .addr (walk_addr),
        .last (walk_last)
    );

    hsrch_hdr_check #(
        .HDR_WORDS(HDR_WORDS),
        .ID_IDX   (ID_IDX),
        .ID_WORD  (ID_WORD)
    ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (chk_clr),
        .en      (q.state == ST_RECV),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .complete(chk_complete),
        .match   (chk_match)
    );

    hsrch_cmd_table u_tbl (
        .attempt (q.attempt),
        .hdr_addr(walk_addr),
        .cmd     (cmd)
    );

    always_comb begin
        d         = q;
        walk_load = 1'b0;
        walk_step = 1'b0;
        chk_clr   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                chk_clr = 1'b1;
                if (start) begin
                    walk_load = 1'b1;
                    d.attempt = ATT_OCTAL;
                    d.state   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                chk_clr = 1'b1;
                if (req_ready) d.state = ST_RECV;
            end
            ST_RECV: begin
                if (chk_complete) begin
                    if (chk_match) begin
                        d.state      = ST_FOUND;
                        d.found      = 1'b1;
                        d.found_addr = walk_addr;
                    end else if (q.attempt != ATT_BASIC) begin
                        d.attempt = attempt_e'(q.attempt + 2'd1);
                        d.state   = ST_ISSUE;
                    end else if (walk_last) begin
                        d.state = ST_LOCK;
                        d.lock  = 1'b1;
                    end else begin
                        walk_step = 1'b1;
                        d.attempt = ATT_OCTAL;
                        d.state   = ST_ISSUE;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_valid      = (q.state == ST_ISSUE);
    assign req_opcode     = cmd.opcode;
    assign req_addr       = cmd.addr;
    assign req_addr_bytes = cmd.addr_bytes;
    assign req_lanes      = cmd.lanes;
    assign req_dummy      = cmd.dummy;
    assign req_len        = LEN_W'(HDR_WORDS * 4);
    assign done           = q.found | q.lock;
    assign found          = q.found;
    assign found_addr     = q.found_addr;
    assign lockdown       = q.lock;
    assign error_out      = q.lock;
    assign tristate_ctl   = q.lock ? 32'hFFFF_FFFF : 32'h0000_0000;

endmodule

// File: rtl/hsrch_seq_chk.sv
module hsrch_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [7:0]  req_opcode,
    input logic [31:0] req_addr,
    input logic [2:0]  req_addr_bytes,
    input logic [3:0]  req_lanes,
    input logic [3:0]  req_dummy,
    input logic        done,
    input logic        found,
    input logic        lockdown,
    input logic        error_out,
    input logic [31:0] tristate_ctl
);

    // R2
    octal_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == 8'h7C) |->
            (req_addr_bytes == 3'd4 && req_lanes == 4'd8 && req_dummy == 4'd8));

    // R4
    basic_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_opcode == 8'h03) |->
            (req_addr[31:24] == 8'h00 && req_addr_bytes == 3'd3 && req_dummy == 4'd0));

    // R8
    lock_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockdown |-> (done && !found && error_out && tristate_ctl == 32'hFFFF_FFFF));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockdown |=> lockdown);

    // R9
    no_req_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockdown |-> !req_valid);

    // R7
    found_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> (found && !req_valid && $stable(found)));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_opcode) && $stable(req_addr) && $stable(req_lanes)));

endmodule

bind hsrch_seq hsrch_seq_chk u_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_opcode    (req_opcode),
    .req_addr      (req_addr),
    .req_addr_bytes(req_addr_bytes),
    .req_lanes     (req_lanes),
    .req_dummy     (req_dummy),
    .done          (done),
    .found         (found),
    .lockdown      (lockdown),
    .error_out     (error_out),
    .tristate_ctl  (tristate_ctl)
);

// File: tb/hsrch_seq_test.sv
module hsrch_seq_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0100_0000;
    localparam int          LIMIT      = 4;
    localparam int          NWORDS     = 4;
    localparam int          IDI        = 2;
    localparam logic [31:0] IDW        = 32'hA5C3_0F96;
    localparam int          LW         = $clog2(NWORDS * 4 + 1);

    int checks = 0;
    int failures = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          start = 1'b0, req_ready = 1'b0, rx_valid = 1'b0;
    logic [31:0]   rx_data = '0;
    logic          req_valid, done, found, lockdown, error_out;
    logic [7:0]    req_opcode;
    logic [31:0]   req_addr, found_addr, tristate_ctl;
    logic [2:0]    req_addr_bytes;
    logic [3:0]    req_lanes, req_dummy;
    logic [LW-1:0] req_len;

    hsrch_seq #(.BASE_ADDR(BASE), .SEARCH_LIMIT(LIMIT), .HDR_WORDS(NWORDS),
                .ID_IDX(IDI), .ID_WORD(IDW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
        .req_ready(req_ready), .req_opcode(req_opcode), .req_addr(req_addr),
        .req_addr_bytes(req_addr_bytes), .req_lanes(req_lanes), .req_dummy(req_dummy),
        .req_len(req_len), .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
        .found(found), .found_addr(found_addr), .lockdown(lockdown),
        .error_out(error_out), .tristate_ctl(tristate_ctl));

    logic          ds_start = 1'b0, ds_ready = 1'b0, ds_rxv = 1'b0;
    logic          ds_valid, ds_done, ds_found, ds_lock, ds_err;
    logic [7:0]    ds_op;
    logic [31:0]   ds_addr, ds_faddr, ds_tri;
    logic [2:0]    ds_ab;
    logic [3:0]    ds_lanes, ds_dummy;
    logic [LW-1:0] ds_len;

    hsrch_seq #(.BASE_ADDR(32'h0), .SEARCH_LIMIT(LIMIT), .HDR_WORDS(NWORDS),
                .ID_IDX(IDI), .ID_WORD(IDW), .DUAL_STACK(1'b1),
                .LOWER_SPAN_LOG2(16)) uut_ds (
        .clk(clk), .rst_n(rst_n), .start(ds_start), .req_valid(ds_valid),
        .req_ready(ds_ready), .req_opcode(ds_op), .req_addr(ds_addr),
        .req_addr_bytes(ds_ab), .req_lanes(ds_lanes), .req_dummy(ds_dummy),
        .req_len(ds_len), .rx_valid(ds_rxv), .rx_data(32'h0), .done(ds_done),
        .found(ds_found), .found_addr(ds_faddr), .lockdown(ds_lock),
        .error_out(ds_err), .tristate_ctl(ds_tri));

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    function automatic logic [7:0] e_op(int a);
        return (a == 0) ? 8'h7C : (a == 1) ? 8'h13 : 8'h03;
    endfunction

    function automatic logic [31:0] hdr_addr(int i);
        return BASE + 32'(i) * 32'h8000;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_req_or_done();
        for (int g = 0; g < 200 && !(req_valid || done); g++) @(negedge clk);
    endtask

    // Runs one search; header matches at (tidx, tatt), or never when tidx < 0.
    task automatic run_search(input int tidx, input int tatt);
        int idx = 0, att = 0, nreq = 0, exp_n;
        logic [31:0] ea;
        do_reset();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            wait_req_or_done();
            if (done || !req_valid) break;
            nreq++;
            ea = hdr_addr(idx);
            if (att == 2) ea = {8'h00, ea[23:0]};
            check(req_opcode == e_op(att), "R5 opcode order", req_opcode, e_op(att));
            check(req_addr == ea, "R6 address", req_addr, ea);
            if (att == 0)
                check(req_addr_bytes == 3'd4 && req_lanes == 4'd8 && req_dummy == 4'd8,
                      "R2 octal fields", {req_addr_bytes, req_lanes, req_dummy}, 11'h488);
            else if (att == 1)
                check(req_addr_bytes == 3'd4 && req_lanes == 4'd1 && req_dummy == 4'd0,
                      "R3 wide fields", {req_addr_bytes, req_lanes, req_dummy}, 11'h410);
            else
                check(req_addr_bytes == 3'd3 && req_lanes == 4'd1 && req_dummy == 4'd0,
                      "R4 basic fields", {req_addr_bytes, req_lanes, req_dummy}, 11'h310);
            check(req_len == LW'(NWORDS * 4), "R12 length", req_len, NWORDS * 4);
            for (int w = 0; w < (idx + att) % 3; w++) begin
                @(negedge clk);
                check(req_valid && req_addr == ea && req_opcode == e_op(att),
                      "R11 hold", {req_valid, req_addr}, {1'b1, ea});
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            for (int w = 0; w < NWORDS; w++) begin
                rx_valid = 1'b1;
                rx_data = (w == IDI && idx == tidx && att == tatt) ? IDW : (IDW ^ 32'(w + 1));
                @(negedge clk);
            end
            rx_valid = 1'b0;
            if (att == 2) begin
                att = 0;
                idx++;
            end else att++;
        end
        if (tidx >= 0) begin
            exp_n = tidx * 3 + tatt + 1;
            check(done && found && !lockdown, "R7 found", {done, found, lockdown}, 3'b110);
            check(found_addr == hdr_addr(tidx), "R7 found_addr", found_addr, hdr_addr(tidx));
            check(tristate_ctl == 32'h0, "R7 tristate idle", tristate_ctl, 0);
            start = 1'b1;
            repeat (5) begin
                @(negedge clk);
                check(!req_valid && found, "R7 quiet after found", req_valid, 0);
            end
            start = 1'b0;
        end else begin
            exp_n = LIMIT * 3;
            check(done && lockdown && error_out && !found, "R8 lockdown",
                  {done, lockdown, error_out, found}, 4'b1110);
            check(tristate_ctl == 32'hFFFF_FFFF, "R8 tristate", tristate_ctl, 32'hFFFF_FFFF);
            start = 1'b1;
            rx_valid = 1'b1;
            rx_data = IDW;
            repeat (8) begin
                @(negedge clk);
                check(!req_valid && lockdown && !found, "R9 sticky lock",
                      {req_valid, lockdown}, 2'b01);
            end
            start = 1'b0;
            rx_valid = 1'b0;
        end
        check(nreq == exp_n, "R5 request count", nreq, exp_n);
    endtask

    initial begin
        #1;
        check(!req_valid && !done && !found && !lockdown && !error_out && tristate_ctl == 0,
              "R1 reset", {req_valid, done, found, lockdown, error_out}, 0);
        do_reset();
        check(!req_valid && !done && !found && !lockdown && !error_out && tristate_ctl == 0,
              "R1 after reset", {req_valid, done, found, lockdown, error_out}, 0);
        for (int t = 0; t < LIMIT; t++)
            for (int a = 0; a < 3; a++)
                run_search(t, a);
        run_search(-1, 0);

        // R10: dual-stacked, 64 KB lower span from address 0
        begin
            int n = 0;
            do_reset();
            ds_start = 1'b1;
            @(negedge clk);
            ds_start = 1'b0;
            forever begin
                for (int g = 0; g < 200 && !(ds_valid || ds_done); g++) @(negedge clk);
                if (ds_done || !ds_valid) break;
                check(ds_addr < 32'h0001_0000, "R10 span", ds_addr, 32'h0000_FFFF);
                n++;
                ds_ready = 1'b1;
                @(negedge clk);
                ds_ready = 1'b0;
                ds_rxv = 1'b1;
                repeat (NWORDS) @(negedge clk);
                ds_rxv = 1'b0;
            end
            check(n == 6, "R10 request count", n, 6);
            check(ds_lock && ds_err && !ds_found && ds_tri == 32'hFFFF_FFFF,
                  "R10 lockdown", {ds_lock, ds_err, ds_found}, 3'b110);
        end
        finish_run();
    end

endmodule